// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block conditions a single external interrupt pin for a clock domain. The pin passes through a synchroniser, and the detector then compares each synchronised sample with the one before it. When the pin moves from its idle level to its active level, a status flag is latched. A polarity control selects whether the active level is low (falling edge) or high (rising edge). A mode control selects one of two behaviours. In pure edge mode, software can clear the flag at any time. In edge-plus-level mode, the flag is held set and clear strobes are ignored for as long as the pin stays active.

The block also tells the pad whether its internal pull device should be on, and in which direction. The pull always points toward the idle level, so a floating pin reads as inactive. The synchronised pin level is available for software to poll. An interrupt request is raised while the flag is set and the local interrupt enable is on. When the detector is disabled, the flag is forced clear and the pull and level outputs are forced off.

Top module: `xirq_detect`

## Requirements
- R1: With `cfg_en_i` = 1, `pin_lvl_o` shows the value `pin_i` had before the second rising clock edge after a change. With `cfg_en_i` = 0, `pin_lvl_o` is 0.
- R2: `cfg_pol_i` = 0 makes low the active level. `cfg_pol_i` = 1 makes high the active level. When the synchronised pin goes from idle to active, `flag_o` becomes 1 after the third rising edge that follows the pin change, and not earlier.
- R3: A change of the pin from active to idle never sets `flag_o`.
- R4: With `cfg_lvl_i` = 0 (edge mode), a one-cycle pulse on `ack_i` clears `flag_o` at the next edge, even while the pin is still active.
- R5: With `cfg_lvl_i` = 1 (edge-plus-level mode), `flag_o` is 1 and `ack_i` has no effect while the synchronised pin is active. Once the pin is idle, `ack_i` clears the flag.
- R6: `irq_o` is 1 exactly when `flag_o` = 1 and `cfg_ie_i` = 1.
- R7: `pull_up_o` = 1 exactly when `cfg_en_i` = 1, `cfg_pull_dis_i` = 0 and `cfg_pol_i` = 0. `pull_dn_o` = 1 exactly when `cfg_en_i` = 1, `cfg_pull_dis_i` = 0 and `cfg_pol_i` = 1.
- R8: While `cfg_en_i` = 0, the following outputs are all 0, whatever the pin does: `flag_o`, `irq_o`, `pull_up_o`, `pull_dn_o` and `pin_lvl_o`.
- R9: If an active edge is detected in the same cycle as an `ack_i` pulse, the flag is set.
- R10: After reset, `flag_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw external pin |
| cfg_en_i | input | 1 | Detector enable |
| cfg_pol_i | input | 1 | Active level: 0 low/falling, 1 high/rising |
| cfg_lvl_i | input | 1 | 0 edge only, 1 edge plus level |
| cfg_pull_dis_i | input | 1 | 1 turns the internal pull off |
| cfg_ie_i | input | 1 | Local interrupt enable |
| ack_i | input | 1 | Flag clear strobe |
| pull_up_o | output | 1 | Pad pull-up enable |
| pull_dn_o | output | 1 | Pad pull-down enable |
| pin_lvl_o | output | 1 | Synchronised pin level |
| flag_o | output | 1 | Latched status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the detector with the default two-stage synchroniser. This gives fixed latencies of two edges to `pin_lvl_o` and three edges to `flag_o`, so every expected value can be written down by cycle. It sweeps all sixteen combinations of polarity, mode, interrupt enable and pull disable. In each combination it asserts the pin, acknowledges the flag, releases the pin and acknowledges again. It also places a clear strobe on the exact cycle of edge detection, which puts the set-versus-clear collision within reach. A separate pass with the detector disabled toggles the pin and checks that every output stays quiet.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    typedef enum logic {
        POL_LOW_FALL  = 1'b0,
        POL_HIGH_RISE = 1'b1
    } xirq_pol_e;

    typedef enum logic {
        MODE_EDGE       = 1'b0,
        MODE_EDGE_LEVEL = 1'b1
    } xirq_mode_e;

    typedef struct packed {
        logic up;
        logic down;
    } xirq_pull_t;

    typedef struct packed {
        logic prev_lvl;
    } xirq_edge_st_t;

    typedef struct packed {
        logic flag;
    } xirq_flag_st_t;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/xirq_edge.sv
module xirq_edge
    import xirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl_i,
    input  xirq_pol_e pol_i,
    output logic      active_o,
    output logic      act_edge_o
);
    xirq_edge_st_t st_d, st_q;
    logic          prev_active;

    always_comb begin
        st_d          = st_q;
        st_d.prev_lvl = lvl_i;
        // polarity is applied to both samples, so a polarity change alone is not an edge
        active_o    = (pol_i == POL_HIGH_RISE) ? lvl_i : ~lvl_i;
        prev_active = (pol_i == POL_HIGH_RISE) ? st_q.prev_lvl : ~st_q.prev_lvl;
        act_edge_o  = active_o & ~prev_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xirq_flag.sv
module xirq_flag
    import xirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  xirq_mode_e mode_i,
    input  logic       active_i,
    input  logic       act_edge_i,
    input  logic       clr_i,
    output logic       flag_o
);
    xirq_flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.flag = 1'b0;
        end else if (act_edge_i) begin
            st_d.flag = 1'b1;                       // set beats a same-cycle clear
        end else if (mode_i == MODE_EDGE_LEVEL && active_i) begin
            st_d.flag = 1'b1;                       // level keeps the flag pinned
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic cfg_en_i,
    input  logic cfg_pol_i,
    input  logic cfg_lvl_i,
    input  logic cfg_pull_dis_i,
    input  logic cfg_ie_i,
    input  logic ack_i,
    output logic pull_up_o,
    output logic pull_dn_o,
    output logic pin_lvl_o,
    output logic flag_o,
    output logic irq_o
);
    xirq_pol_e  pol;
    xirq_mode_e mode;
    xirq_pull_t pull;
    logic       sync_lvl;
    logic       active;
    logic       act_edge;
    logic       flag;

    assign pol  = xirq_pol_e'(cfg_pol_i);
    assign mode = xirq_mode_e'(cfg_lvl_i);

    xirq_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b0)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_lvl)
    );

    xirq_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (sync_lvl),
        .pol_i      (pol),
        .active_o   (active),
        .act_edge_o (act_edge)
    );

    xirq_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (cfg_en_i),
        .mode_i     (mode),
        .active_i   (active),
        .act_edge_i (act_edge),
        .clr_i      (ack_i),
        .flag_o     (flag)
    );

    always_comb begin
        pull = '0;
        if (cfg_en_i && !cfg_pull_dis_i) begin
            // pull toward the idle level
            pull.up   = (pol == POL_LOW_FALL);
            pull.down = (pol == POL_HIGH_RISE);
        end
    end

    assign pull_up_o = pull.up;
    assign pull_dn_o = pull.down;
    assign pin_lvl_o = cfg_en_i & sync_lvl;
    assign flag_o    = flag;
    assign irq_o     = flag & cfg_ie_i;
endmodule

// File: rtl/xirq_detect_chk.sv
module xirq_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en_i,
    input logic cfg_pol_i,
    input logic cfg_lvl_i,
    input logic cfg_ie_i,
    input logic pull_up_o,
    input logic pull_dn_o,
    input logic pin_lvl_o,
    input logic flag_o,
    input logic irq_o
);
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ie_i |-> !irq_o); // R6

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pull_up_o && pull_dn_o)); // R7

    AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en_i |=> !flag_o); // R8

    AST_LEVEL_PINS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en_i && cfg_lvl_i && (pin_lvl_o == cfg_pol_i)) |=> flag_o); // R5

    AST_SET_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> ($past(cfg_en_i) && ($past(pin_lvl_o) == $past(cfg_pol_i)))); // R2
endmodule

bind xirq_detect xirq_detect_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en_i  (cfg_en_i),
    .cfg_pol_i (cfg_pol_i),
    .cfg_lvl_i (cfg_lvl_i),
    .cfg_ie_i  (cfg_ie_i),
    .pull_up_o (pull_up_o),
    .pull_dn_o (pull_dn_o),
    .pin_lvl_o (pin_lvl_o),
    .flag_o    (flag_o),
    .irq_o     (irq_o)
);

// File: tb/xirq_detect_tb.sv
module xirq_detect_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_i = 1'b0;
    logic cfg_en_i = 1'b0, cfg_pol_i = 1'b0, cfg_lvl_i = 1'b0;
    logic cfg_pull_dis_i = 1'b0, cfg_ie_i = 1'b0, ack_i = 1'b0;
    logic pull_up_o, pull_dn_o, pin_lvl_o, flag_o, irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    xirq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_en_i(cfg_en_i),
        .cfg_pol_i(cfg_pol_i), .cfg_lvl_i(cfg_lvl_i), .cfg_pull_dis_i(cfg_pull_dis_i),
        .cfg_ie_i(cfg_ie_i), .ack_i(ack_i), .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o),
        .pin_lvl_o(pin_lvl_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (pol=%0b lvl=%0b ie=%0b pd=%0b) t=%0t",
                     req, act, exp, cfg_pol_i, cfg_lvl_i, cfg_ie_i, cfg_pull_dis_i, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1;
        tick(1);
        ack_i = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        check("R10 flag", flag_o, 1'b0);
        check("R10 irq", irq_o, 1'b0);
        rst_n = 1'b1;
        tick(2);

        for (int c = 0; c < 16; c++) begin
            logic pol, lvl, ie, pd;
            {pol, lvl, ie, pd} = 4'(c);
            cfg_en_i = 1'b1; cfg_pol_i = pol; cfg_lvl_i = lvl;
            cfg_ie_i = ie; cfg_pull_dis_i = pd;
            pin_i = ~pol;
            tick(4);
            pulse_ack();
            check("R7 pull up", pull_up_o, !pd && !pol);
            check("R7 pull down", pull_dn_o, !pd && pol);
            check("R3 idle flag", flag_o, 1'b0);
            check("R6 idle irq", irq_o, 1'b0);

            // assert the pin and follow the latency chain
            pin_i = pol;
            tick(1);
            check("R1 lvl old", pin_lvl_o, ~pol);
            tick(1);
            check("R1 lvl new", pin_lvl_o, pol);
            check("R2 not yet", flag_o, 1'b0);
            tick(1);
            check("R2 flag set", flag_o, 1'b1);
            check("R6 irq", irq_o, ie);

            // clear while still active
            pulse_ack();
            check(lvl ? "R5 ack ignored" : "R4 ack clears", flag_o, lvl);

            // release the pin
            pin_i = ~pol;
            tick(3);
            check("R3 release", flag_o, lvl);
            pulse_ack();
            check("R5 ack after release", flag_o, 1'b0);
            check("R6 irq off", irq_o, 1'b0);

            // clear strobe in the edge-detect cycle
            pin_i = pol;
            @(posedge clk); @(posedge clk); @(negedge clk);
            ack_i = 1'b1;
            tick(1);
            ack_i = 1'b0;
            check("R9 set wins", flag_o, 1'b1);
            pulse_ack();
            check(lvl ? "R5 ack ignored again" : "R4 ack clears again", flag_o, lvl);
            pin_i = ~pol;
            tick(3);
            pulse_ack();
        end

        // disabled: toggle the pin, nothing must react
        cfg_en_i = 1'b0; cfg_pol_i = 1'b0; cfg_lvl_i = 1'b1;
        cfg_ie_i = 1'b1; cfg_pull_dis_i = 1'b0;
        for (int k = 0; k < 8; k++) begin
            pin_i = k[0];
            tick(2);
            check("R8 flag", flag_o, 1'b0);
            check("R8 irq", irq_o, 1'b0);
            check("R8 pull up", pull_up_o, 1'b0);
            check("R8 pull down", pull_dn_o, 1'b0);
            check("R1 lvl gated", pin_lvl_o, 1'b0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule